// File: doc/BRIEF.md
# Doorbell Request Responder

This block terminates doorbell requests that arrive already split into fields. Each request is addressed to one device; when it is meant for this device and well formed, its 16-bit info word and the sender's ID go into a small first-in first-out receive queue that local logic empties at its own pace. Every accepted request that is addressed here gets exactly one response. The response goes back to the sender, reuses the request's transaction ID and reports whether the event was stored.

The queue's occupancy chooses the response status directly. A request that finds the queue full is not stalled and is not silently lost. It is answered with a Retry status so the sender repeats it later. Requests of another format, or for another device, produce no response and only advance a saturating drop counter. Responses leave through a valid/ready handshake backed by a one-entry skid register. The request side therefore stalls only when one response is waiting at the output and a second is already held behind it.

Top module: `dbell_resp`

## Requirements
- R1: An accepted request with format code 4'b1010, destination equal to `self_id`, reserved field zero and a queue holding fewer than QDEPTH entries stores {source ID, info} in the queue and answers with status 4'b0000 (Done).
- R2: Every response carries transport type 2'b00, format code 4'b1101, transaction type 4'b0000, the request's transaction ID, the request's source ID as destination and `self_id` as source.
- R3: A request that would otherwise be stored, arriving while the queue holds QDEPTH entries, is answered with status 4'b0011 (Retry) and leaves the queue contents unchanged.
- R4: Fullness is judged on the occupancy before the current cycle's pop, so a pop in the same cycle as a request to a full queue still gives Retry.
- R5: A doorbell for this device with a nonzero reserved field is answered with status 4'b0111 (Error) and is not stored, even when the queue is full.
- R6: A request with any other format code, or with a destination other than `self_id`, gets no response and no queue entry, and `drop_count` rises by one, holding at its all-ones value.
- R7: The queue returns entries in arrival order, `q_valid` is high exactly when it holds an entry, and `q_pop` while it is empty has no effect.
- R8: A response is presented on the cycle after its request is accepted and holds every field unchanged while `rsp_ready` is low.
- R9: `req_ready` stays high while one response waits at the output and goes low only when a second is held behind it; held responses leave in order without loss.
- R10: After reset, `rsp_valid`, `q_valid` and `drop_count` are zero and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| self_id | input | 8 | ID of this device |
| req_valid | input | 1 | Request fields are valid |
| req_ready | output | 1 | Request is accepted on this edge |
| req_ftype | input | 4 | Request format code |
| req_rsvd | input | 8 | Request reserved field |
| req_tid | input | 8 | Request transaction ID |
| req_dst | input | 8 | Request destination ID |
| req_src | input | 8 | Request source ID |
| req_info | input | 16 | Doorbell info word |
| rsp_valid | output | 1 | Response fields are valid |
| rsp_ready | input | 1 | Response is taken on this edge |
| rsp_tt | output | 2 | Response transport type |
| rsp_ftype | output | 4 | Response format code |
| rsp_ttype | output | 4 | Response transaction type |
| rsp_status | output | 4 | Response status |
| rsp_tid | output | 8 | Response transaction ID |
| rsp_dst | output | 8 | Response destination ID |
| rsp_src | output | 8 | Response source ID |
| q_valid | output | 1 | Queue head is valid |
| q_pop | input | 1 | Remove the queue head |
| q_src | output | 8 | Sender ID at the queue head |
| q_info | output | 16 | Info word at the queue head |
| drop_count | output | 8 | Saturating count of dropped requests |

## Verification
The assertions check, on every cycle, that the output holds while it is stalled, that a skid-held response is the next one presented, that nothing is ever pushed into a full queue, that an empty queue stays empty when popped, that dropped requests advance the counter, and that the response source is the local ID. What they cannot show is whether the right status was chosen. The Done-to-Retry boundary at the queue depth, the pop-in-the-same-cycle case, the Error precedence and the exact order of queued data are shown only by the bench's scenarios. The bench compares these against a model queue and its own counters.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
    localparam int ID_W    = 8;
    localparam int TID_W   = 8;
    localparam int INFO_W  = 16;
    localparam int RSVD_W  = 8;
    localparam int FT_W    = 4;
    localparam int TT_W    = 2;
    localparam int TTYPE_W = 4;
    localparam int ST_W    = 4;

    localparam logic [FT_W-1:0]    FT_DOORBELL  = 4'd10;
    localparam logic [FT_W-1:0]    FT_RESPONSE  = 4'd13;
    localparam logic [TTYPE_W-1:0] TTYPE_NODATA = 4'd0;
    localparam logic [TT_W-1:0]    TT_SMALL     = 2'b00;

    typedef enum logic [ST_W-1:0] {
        ST_DONE  = 4'b0000,
        ST_RETRY = 4'b0011,
        ST_ERROR = 4'b0111
    } dbst_e;

    typedef enum logic [1:0] {
        ACT_DROP,
        ACT_QUEUE,
        ACT_RETRY,
        ACT_ERROR
    } act_e;

    typedef struct packed {
        logic [TT_W-1:0]    tt;
        logic [FT_W-1:0]    ftype;
        logic [TTYPE_W-1:0] ttype;
        dbst_e              status;
        logic [TID_W-1:0]   tid;
        logic [ID_W-1:0]    dst;
        logic [ID_W-1:0]    src;
    } rsp_t;

    typedef struct packed {
        logic [ID_W-1:0]   src;
        logic [INFO_W-1:0] info;
    } qent_t;
endpackage

// File: rtl/dbell_classify.sv
module dbell_classify
    import dbell_pkg::*;
(
    input  logic [FT_W-1:0]   ftype,
    input  logic [ID_W-1:0]   dst,
    input  logic [RSVD_W-1:0] rsvd,
    input  logic [ID_W-1:0]   self_id,
    input  logic              q_full,
    output act_e              act
);
    logic for_us;
    logic bad_rsvd;

    always_comb begin
        for_us   = (ftype == FT_DOORBELL) && (dst == self_id);
        bad_rsvd = (rsvd != '0);
        if (!for_us) begin
            act = ACT_DROP;
        end else if (bad_rsvd) begin
            act = ACT_ERROR;
        end else if (q_full) begin
            act = ACT_RETRY;
        end else begin
            act = ACT_QUEUE;
        end
    end
endmodule

// File: rtl/dbell_rxq.sv
module dbell_rxq #(
    parameter int DEPTH = 4,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_dat,
    input  logic         pop,
    output logic         vld,
    output logic [W-1:0] dat,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t q, d;
    logic do_push;
    logic do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (q.cnt != CW'(DEPTH));
        if (do_push) begin
            d.mem[q.wp] = push_dat;
            d.wp        = nxt(q.wp);
        end
        if (do_pop) begin
            d.rp = nxt(q.rp);
        end
        unique case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign vld  = (q.cnt != '0);
    assign dat  = q.mem[q.rp];
    assign full = (q.cnt == CW'(DEPTH));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q.cnt < CW'(DEPTH)));

    p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.cnt == '0) && !push) |=> (q.cnt == '0));
endmodule

// File: rtl/dbell_skid.sv
module dbell_skid #(
    parameter int W = 38
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    output logic         in_rdy,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    input  logic         out_rdy,
    output logic [W-1:0] out_dat
);
    typedef struct packed {
        logic         out_vld;
        logic [W-1:0] out_dat;
        logic         sk_vld;
        logic [W-1:0] sk_dat;
    } st_t;

    st_t q, d;
    logic take;
    logic drain;

    always_comb begin
        d     = q;
        take  = in_vld && !q.sk_vld;
        drain = q.out_vld && out_rdy;
        if (q.sk_vld) begin
            if (drain) begin
                d.out_vld = 1'b1;
                d.out_dat = q.sk_dat;
                d.sk_vld  = 1'b0;
            end
        end else begin
            if (drain) d.out_vld = 1'b0;
            if (take) begin
                if (!q.out_vld || drain) begin
                    d.out_vld = 1'b1;
                    d.out_dat = in_dat;
                end else begin
                    d.sk_vld = 1'b1;
                    d.sk_dat = in_dat;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_rdy  = !q.sk_vld;
    assign out_vld = q.out_vld;
    assign out_dat = q.out_dat;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_dat)));

    p_skid_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sk_vld && out_rdy) |=> (out_vld && (out_dat == $past(q.sk_dat))));
endmodule

// File: rtl/dbell_resp.sv
module dbell_resp
    import dbell_pkg::*;
#(
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ID_W-1:0]    self_id,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [FT_W-1:0]    req_ftype,
    input  logic [RSVD_W-1:0]  req_rsvd,
    input  logic [TID_W-1:0]   req_tid,
    input  logic [ID_W-1:0]    req_dst,
    input  logic [ID_W-1:0]    req_src,
    input  logic [INFO_W-1:0]  req_info,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [TT_W-1:0]    rsp_tt,
    output logic [FT_W-1:0]    rsp_ftype,
    output logic [TTYPE_W-1:0] rsp_ttype,
    output logic [ST_W-1:0]    rsp_status,
    output logic [TID_W-1:0]   rsp_tid,
    output logic [ID_W-1:0]    rsp_dst,
    output logic [ID_W-1:0]    rsp_src,
    output logic               q_valid,
    input  logic               q_pop,
    output logic [ID_W-1:0]    q_src,
    output logic [INFO_W-1:0]  q_info,
    output logic [CNT_W-1:0]   drop_count
);
    localparam int QW = $bits(qent_t);
    localparam int RW = $bits(rsp_t);

    typedef struct packed {
        logic [CNT_W-1:0] drops;
    } st_t;

    st_t   q, d;
    act_e  act;
    logic  acc;
    logic  q_full;
    logic  q_push;
    logic  rsp_push;
    qent_t q_in;
    qent_t q_out;
    rsp_t  rsp_in;
    rsp_t  rsp_out;
    logic [QW-1:0] q_out_bits;
    logic [RW-1:0] rsp_out_bits;

    dbell_classify u_cls (
        .ftype   (req_ftype),
        .dst     (req_dst),
        .rsvd    (req_rsvd),
        .self_id (self_id),
        .q_full  (q_full),
        .act     (act)
    );

    always_comb begin
        d        = q;
        acc      = req_valid && req_ready;
        q_push   = acc && (act == ACT_QUEUE);
        rsp_push = acc && (act != ACT_DROP);
        if (acc && (act == ACT_DROP) && (q.drops != '1)) begin
            d.drops = q.drops + CNT_W'(1);
        end
        q_in.src      = req_src;
        q_in.info     = req_info;
        rsp_in.tt     = TT_SMALL;
        rsp_in.ftype  = FT_RESPONSE;
        rsp_in.ttype  = TTYPE_NODATA;
        rsp_in.tid    = req_tid;
        rsp_in.dst    = req_src;
        rsp_in.src    = self_id;
        unique case (act)
            ACT_RETRY: rsp_in.status = ST_RETRY;
            ACT_ERROR: rsp_in.status = ST_ERROR;
            default:   rsp_in.status = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    dbell_rxq #(.DEPTH(QDEPTH), .W(QW)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_dat (q_in),
        .pop      (q_pop),
        .vld      (q_valid),
        .dat      (q_out_bits),
        .full     (q_full)
    );

    dbell_skid #(.W(RW)) u_skid (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (rsp_push),
        .in_rdy  (req_ready),
        .in_dat  (rsp_in),
        .out_vld (rsp_valid),
        .out_rdy (rsp_ready),
        .out_dat (rsp_out_bits)
    );

    assign q_out      = qent_t'(q_out_bits);
    assign rsp_out    = rsp_t'(rsp_out_bits);
    assign q_src      = q_out.src;
    assign q_info     = q_out.info;
    assign rsp_tt     = rsp_out.tt;
    assign rsp_ftype  = rsp_out.ftype;
    assign rsp_ttype  = rsp_out.ttype;
    assign rsp_status = rsp_out.status;
    assign rsp_tid    = rsp_out.tid;
    assign rsp_dst    = rsp_out.dst;
    assign rsp_src    = rsp_out.src;
    assign drop_count = q.drops;

    p_drop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (act == ACT_DROP)) |=>
            ((drop_count == $past(drop_count) + CNT_W'(1)) || ($past(drop_count) == '1)));

    p_rsp_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_src == self_id) && (rsp_ftype == FT_RESPONSE)));
endmodule

// File: tb/dbell_resp_test.sv
module dbell_resp_test;
    localparam int DEPTH = 4;
    localparam logic [7:0] SELF = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_ftype = '0;
    logic [7:0]  req_rsvd = '0;
    logic [7:0]  req_tid = '0;
    logic [7:0]  req_dst = '0;
    logic [7:0]  req_src = '0;
    logic [15:0] req_info = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_tt;
    logic [3:0]  rsp_ftype, rsp_ttype, rsp_status;
    logic [7:0]  rsp_tid, rsp_dst, rsp_src;
    logic        q_valid;
    logic        q_pop = 1'b0;
    logic [7:0]  q_src;
    logic [15:0] q_info;
    logic [7:0]  drop_count;

    int checks = 0;
    int errors = 0;
    int drops_exp = 0;
    logic [23:0] mq[$];

    dbell_resp #(.QDEPTH(DEPTH), .CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .self_id(SELF),
        .req_valid(req_valid), .req_ready(req_ready), .req_ftype(req_ftype),
        .req_rsvd(req_rsvd), .req_tid(req_tid), .req_dst(req_dst),
        .req_src(req_src), .req_info(req_info),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tt(rsp_tt),
        .rsp_ftype(rsp_ftype), .rsp_ttype(rsp_ttype), .rsp_status(rsp_status),
        .rsp_tid(rsp_tid), .rsp_dst(rsp_dst), .rsp_src(rsp_src),
        .q_valid(q_valid), .q_pop(q_pop), .q_src(q_src), .q_info(q_info),
        .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string r, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", r, got, exp);
        end
    endtask

    task automatic send(input logic [3:0] ft, input logic [7:0] rsvd, input logic [7:0] tid,
                        input logic [7:0] dst, input logic [7:0] src, input logic [15:0] info,
                        input logic pop);
        @(negedge clk);
        req_ftype = ft; req_rsvd = rsvd; req_tid = tid;
        req_dst = dst; req_src = src; req_info = info;
        req_valid = 1'b1; q_pop = pop;
        @(negedge clk);
        req_valid = 1'b0; q_pop = 1'b0;
    endtask

    task automatic chk_rsp(input string r, input logic [3:0] st, input logic [7:0] tid,
                           input logic [7:0] dst);
        chk(r, {rsp_valid, rsp_tt, rsp_ftype, rsp_ttype, rsp_status, rsp_tid, rsp_dst, rsp_src},
               {1'b1, 2'b00, 4'b1101, 4'b0000, st, tid, dst, SELF});
    endtask

    task automatic doorbell(input string r, input logic [7:0] tid, input logic [7:0] src,
                            input logic [15:0] info);
        logic [3:0] st;
        st = (mq.size() < DEPTH) ? 4'b0000 : 4'b0011;
        send(4'd10, 8'h00, tid, SELF, src, info, 1'b0);
        if (st == 4'b0000) mq.push_back({src, info});
        chk_rsp(r, st, tid, src);
    endtask

    task automatic pop_chk(input string r);
        @(negedge clk);
        chk(r, {q_valid, q_src, q_info}, {1'b1, mq.pop_front()});
        q_pop = 1'b1;
        @(negedge clk);
        q_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 reset", {rsp_valid, q_valid, drop_count, req_ready}, {1'b0, 1'b0, 8'h00, 1'b1});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", {rsp_valid, q_valid, drop_count, req_ready}, {1'b0, 1'b0, 8'h00, 1'b1});

        // R1, R2, R3: fill past depth, Done then Retry
        for (int i = 0; i < 6; i++) begin
            doorbell(i < DEPTH ? "R1 R2 fill" : "R3 full retry",
                     8'(i * 37 + 3), 8'(8'h10 + i), 16'hA000 ^ 16'(i * 16'h0123));
        end

        // R4: pop in the same cycle as a request to a full queue
        chk("R4 head", {q_valid, q_src, q_info}, {1'b1, mq[0]});
        send(4'd10, 8'h00, 8'hC4, SELF, 8'h77, 16'hBEEF, 1'b1);
        chk_rsp("R4 same-cycle pop retry", 4'b0011, 8'hC4, 8'h77);
        void'(mq.pop_front());
        doorbell("R4 space after pop", 8'hC5, 8'h78, 16'h1234);

        // R7: drain in order, then empty pops ignored
        for (int i = 0; i < DEPTH; i++) pop_chk("R7 order");
        @(negedge clk);
        chk("R7 empty", q_valid, 1'b0);
        q_pop = 1'b1;
        repeat (2) @(negedge clk);
        q_pop = 1'b0;
        chk("R7 pop empty ignored", q_valid, 1'b0);
        doorbell("R7 after empty pop", 8'h21, 8'h33, 16'h0F0F);
        pop_chk("R7 single entry");
        @(negedge clk);
        chk("R7 empty again", q_valid, 1'b0);

        // R5: nonzero reserved field gives Error and no entry
        send(4'd10, 8'h01, 8'h40, SELF, 8'h41, 16'h1111, 1'b0);
        chk_rsp("R5 error rsvd 01", 4'b0111, 8'h40, 8'h41);
        send(4'd10, 8'hFF, 8'h42, SELF, 8'h43, 16'h2222, 1'b0);
        chk_rsp("R5 error rsvd FF", 4'b0111, 8'h42, 8'h43);
        @(negedge clk);
        chk("R5 nothing queued", q_valid, 1'b0);
        for (int i = 0; i < DEPTH; i++) doorbell("R1 refill", 8'(i), 8'(i + 1), 16'(i));
        send(4'd10, 8'h80, 8'h44, SELF, 8'h45, 16'h3333, 1'b0);
        chk_rsp("R5 error wins over full", 4'b0111, 8'h44, 8'h45);

        // R6: wrong format codes and wrong destinations are dropped
        for (int f = 0; f < 16; f++) begin
            if (f != 10) begin
                send(4'(f), 8'h00, 8'(f), SELF, 8'h66, 16'h4444, 1'b0);
                drops_exp++;
                chk("R6 ftype dropped no rsp", rsp_valid, 1'b0);
            end
        end
        for (int k = 0; k < 4; k++) begin
            send(4'd10, 8'h00, 8'h50, SELF ^ 8'(1 << k), 8'h66, 16'h5555, 1'b0);
            drops_exp++;
            chk("R6 dst dropped no rsp", rsp_valid, 1'b0);
        end
        @(negedge clk);
        chk("R6 count", drop_count, 64'(drops_exp));
        for (int i = 0; i < 4; i++) pop_chk("R6 queue untouched");
        for (int i = 0; i < 260; i++) send(4'd3, 8'h00, 8'h00, SELF, 8'h00, 16'h0, 1'b0);
        @(negedge clk);
        chk("R6 saturate", drop_count, 64'd255);

        // R8, R9: stall the output
        rsp_ready = 1'b0;
        doorbell("R8 first rsp", 8'hA1, 8'h31, 16'hAAAA);
        chk("R9 ready with one held", req_ready, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_rsp("R8 hold", 4'b0000, 8'hA1, 8'h31);
        end
        send(4'd10, 8'h00, 8'hB2, SELF, 8'h32, 16'hBBBB, 1'b0);
        mq.push_back({8'h32, 16'hBBBB});
        chk("R9 ready low with two", req_ready, 1'b0);
        chk_rsp("R9 first still out", 4'b0000, 8'hA1, 8'h31);
        rsp_ready = 1'b1;
        @(negedge clk);
        chk_rsp("R9 second follows", 4'b0000, 8'hB2, 8'h32);
        chk("R9 ready back", req_ready, 1'b1);
        @(negedge clk);
        chk("R9 output empty", rsp_valid, 1'b0);
        pop_chk("R9 queue first");
        pop_chk("R9 queue second");

        finish_run();
    end
endmodule